// File: doc/BRIEF.md
# Level-Shifted Dual-Carrier Unipolar PWM Generator

This block produces the two polarity-aware control levels of a single-phase current-source inverter modulator, called A (`drive_a`) and B (`drive_b`) here. It compares one signed modulation value against two triangular carriers that are stacked on top of each other. The upper carrier runs from zero to positive full scale. The lower carrier runs from negative full scale to zero. A is high while the modulation is above the upper carrier, and B is high while it is above the lower carrier. During a positive half cycle of the reference, A toggles between the positive transfer state (A=1, B=1) and a zero-output state (A=0, B=1) in which the DC-link inductor charges. During a negative half cycle, B toggles between the zero-output state and the negative transfer state (A=0, B=0).

Both carriers come from one shared up/down counter, so they can never drift out of phase. The peak count is set at run time on `carrier_top`, and that value is also the modulation full scale. The modulation value comes either from the `mod_sample` input or from an internal phase-accumulator sine source. Whichever source is in use, it is captured only when the carrier is at its peak, so a comparison never sees a value that changes in the middle of a carrier period. For example, a 60 kHz carrier with a 60 Hz reference gives one thousand carrier periods per reference cycle.

Top module: `lscpwm_top`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block clears its state after that edge: `drive_a`=0, `drive_b`=1 (a zero-output state), `combo_err`=0, and the carrier count is zero.
- R2: The carrier count steps by exactly one per clock. It counts 0, 1, … up to `carrier_top`, then back down to 0, so one period lasts 2·`carrier_top` clocks. `carrier_peak` is high in the cycle where the count equals `carrier_top`.
- R3: The modulation value is captured only at the clock edge that ends a `carrier_peak` cycle. A change of `mod_sample` at any other time has no effect on `drive_a` or `drive_b` until the next peak.
- R4: `drive_a` is registered. It is 1 when the captured value is strictly greater than the count (the upper carrier). For a captured value m with 0 < m ≤ top, A is high for 2m−1 clocks of each period. It is high for 0 clocks when m = 0, and for all 2·top clocks when m > top.
- R5: `drive_b` is registered. It is 1 when the captured value is strictly greater than count − top (the lower carrier). For m ≥ 1, B is high for the whole period. For m = 0, B is high for 2·top−1 clocks. For −top ≤ m < 0, B is high for 2(m+top)−1 clocks, which is 0 clocks at m = −top.
- R6: The pair A=1, B=0 never appears. `combo_err` goes high and stays high until reset if it ever does.
- R7: When `use_int_sine` is 1, the captured value comes from an internal sine source instead of `mod_sample`. A phase accumulator advances by `phase_step` each clock. Its magnitude never exceeds `carrier_top`, and its sign follows the accumulator MSB, so over one reference cycle both A pulses and B gaps appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_sample | input | CNT_W+1 | Signed external modulation value, in carrier counts |
| carrier_top | input | CNT_W | Peak count of the carriers and modulation full scale |
| use_int_sine | input | 1 | 1 selects the internal sine source |
| phase_step | input | PH_W | Phase increment per clock for the internal sine |
| drive_a | output | 1 | Comparison against the upper carrier |
| drive_b | output | 1 | Comparison against the lower carrier |
| carrier_peak | output | 1 | High while the count is at its peak |
| combo_err | output | 1 | Sticky flag for the illegal pair A=1, B=0 |

## Verification
The bench measures how many clocks A and B are high over one full carrier period at the extremes: modulation zero, exactly plus and minus full scale, one count inside the negative limit, and beyond full scale. Using ≥ instead of >, or an off-by-one turn-around, shifts these counts by one. The bench changes `mod_sample` right after a capture and expects the pulse widths to follow the old value; a design that compares against the live input would show the new value's duty. It also measures the peak-to-peak spacing for two carrier tops, where a counter that dwells at either end of its range gives an odd period. A run with the internal sine must show both positive and negative activity and no illegal pair.

// File: rtl/lscpwm_pkg.sv
`timescale 1ns/1ps
// Package lscpwm_pkg
// Shared types for the level-shifted dual-carrier PWM generator.
// Assumes: a carrier never has more than one direction bit of state.
package lscpwm_pkg;

    // Direction of the shared triangular counter
    typedef enum logic {
        RAMP_DOWN = 1'b0,
        RAMP_UP   = 1'b1
    } ramp_e;

    // Output pair decode: {A,B}
    typedef enum logic [1:0] {
        ST_NEG  = 2'b00,   // A=0 B=0: negative transfer
        ST_ZERO = 2'b01,   // A=0 B=1: zero output, inductor charges
        ST_BAD  = 2'b10,   // A=1 B=0: cannot occur with stacked carriers
        ST_POS  = 2'b11    // A=1 B=1: positive transfer
    } pair_e;

endpackage

// File: rtl/lscpwm_carrier.sv
`timescale 1ns/1ps
// Module lscpwm_carrier
// Shared up/down counter that forms both carriers: the upper carrier is the
// count itself and the lower carrier is count minus top. Flags the peak.
// Assumes: top_i is held steady in normal use; top_i = 0 parks the count at 0.
module lscpwm_carrier
    import lscpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             peak_o
);

    logic [CNT_W-1:0] cnt_q;
    ramp_e            dir_q;

    // Triangular count: up to top, down to zero, one step per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= RAMP_UP;
        end else if (top_i == '0) begin
            cnt_q <= '0;
            dir_q <= RAMP_UP;
        end else if (dir_q == RAMP_UP) begin
            if (cnt_q >= top_i) begin
                cnt_q <= cnt_q - CNT_W'(1);
                dir_q <= RAMP_DOWN;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else begin
            if (cnt_q == '0) begin
                cnt_q <= CNT_W'(1);
                dir_q <= RAMP_UP;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // Peak strobe taken straight from the count
    always_comb begin
        peak_o = (cnt_q == top_i);
    end

    assign cnt_o = cnt_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (top_i != '0 && cnt_q <= top_i) |=>
        (cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == $past(cnt_q) - CNT_W'(1))); // R2

    AST_PEAK_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_o && top_i != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2

endmodule

// File: rtl/lscpwm_sine.sv
`timescale 1ns/1ps
// Module lscpwm_sine
// Internal modulation source: a phase accumulator feeding a parabolic
// half-wave shaper, computed with no table. The magnitude is scaled to the
// carrier top and the sign is taken from the accumulator MSB.
// Assumes: PH_W >= 4; one clock of latency from top_i to the output.
module lscpwm_sine #(
    parameter int CNT_W = 8,
    parameter int PH_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PH_W-1:0]         step_i,
    input  logic [CNT_W-1:0]        top_i,
    output logic signed [CNT_W:0]   mod_o
);

    localparam int FR    = PH_W - 1;          // fraction bits of half-cycle phase
    localparam int PRODW = 2 * FR + 1;        // width of x*(1-x) product
    localparam int SCLW  = FR + CNT_W + 1;    // width of scaled magnitude

    logic [PH_W-1:0]  acc_q;
    logic [FR-1:0]    frac;
    logic [FR:0]      compl;
    logic [PRODW-1:0] prod;
    logic [FR:0]      shape;
    logic [SCLW-1:0]  scaled;
    logic [CNT_W-1:0] mag_d;
    logic [CNT_W-1:0] mag_q;
    logic             neg_q;

    // Phase accumulator, wraps freely
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + step_i;
    end

    // Parabola 4x(1-x) over each half cycle, scaled to top
    always_comb begin
        frac   = acc_q[FR-1:0];
        compl  = {1'b1, {FR{1'b0}}} - {1'b0, frac};
        prod   = PRODW'(frac) * PRODW'(compl);
        shape  = (FR+1)'(prod >> (FR - 2));
        scaled = SCLW'(shape) * SCLW'(top_i);
        mag_d  = CNT_W'(scaled >> FR);
    end

    // Register magnitude and sign
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            neg_q <= 1'b0;
        end else begin
            mag_q <= mag_d;
            neg_q <= acc_q[PH_W-1];
        end
    end

    // Apply sign to form the signed modulation value
    always_comb begin
        mod_o = neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});
    end

    AST_SINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(top_i) |-> (mag_q <= top_i)); // R7

endmodule

// File: rtl/lscpwm_compare.sv
`timescale 1ns/1ps
// Module lscpwm_compare
// Captures the modulation value at each carrier peak and compares it with
// the upper carrier (count) and the lower carrier (count - top). It registers
// A and B and keeps a sticky flag for the illegal pair A=1, B=0.
// Assumes: cnt_i <= top_i, as produced by lscpwm_carrier.
module lscpwm_compare
    import lscpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [CNT_W:0] mod_i,
    input  logic [CNT_W-1:0]      cnt_i,
    input  logic [CNT_W-1:0]      top_i,
    input  logic                  peak_i,
    output logic                  a_o,
    output logic                  b_o,
    output logic                  err_o
);

    localparam int MOD_W = CNT_W + 1;

    logic signed [MOD_W-1:0] held_q;
    logic signed [MOD_W-1:0] upper;
    logic signed [MOD_W-1:0] lower;
    logic                    a_q;
    logic                    b_q;
    logic                    err_q;
    pair_e                   pair;

    // Capture modulation only at the carrier peak
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (peak_i) held_q <= mod_i;
    end

    // Form the two stacked carriers from the shared count
    always_comb begin
        upper = $signed({1'b0, cnt_i});
        lower = upper - $signed({1'b0, top_i});
    end

    // Register both comparisons; reset lands in the zero-output state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b1;
        end else begin
            a_q <= (held_q > upper);
            b_q <= (held_q > lower);
        end
    end

    // Sticky flag for the pair A=1, B=0
    always_ff @(posedge clk) begin
        if (!rst_n)          err_q <= 1'b0;
        else if (a_q && !b_q) err_q <= 1'b1;
    end

    // Decode the output pair for checking
    always_comb begin
        pair = pair_e'({a_q, b_q});
    end

    assign a_o   = a_q;
    assign b_o   = b_q;
    assign err_o = err_q;

    AST_RESET_ZERO_STATE: assert property (@(posedge clk)
        !rst_n |=> (!a_q && b_q && !err_q)); // R1

    AST_HOLD_BETWEEN_PEAKS: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_i |=> $stable(held_q)); // R3

    AST_LEGAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        pair != ST_BAD); // R6

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !err_q); // R6

endmodule

// File: rtl/lscpwm_top.sv
`timescale 1ns/1ps
// Module lscpwm_top
// Level-shifted dual-carrier unipolar PWM generator. It ties the shared
// carrier counter, the optional internal sine source and the peak-captured
// comparator together.
// Assumes: the modulation full scale equals carrier_top, in carrier counts.
module lscpwm_top #(
    parameter int CNT_W    = 8,
    parameter int PH_W     = 16,
    parameter bit HAS_SINE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [CNT_W:0] mod_sample,
    input  logic [CNT_W-1:0]      carrier_top,
    input  logic                  use_int_sine,
    input  logic [PH_W-1:0]       phase_step,
    output logic                  drive_a,
    output logic                  drive_b,
    output logic                  carrier_peak,
    output logic                  combo_err
);

    logic [CNT_W-1:0]      cnt;
    logic                  peak;
    logic signed [CNT_W:0] sine_mod;
    logic signed [CNT_W:0] mod_sel;

    lscpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .top_i  (carrier_top),
        .cnt_o  (cnt),
        .peak_o (peak)
    );

    generate
        if (HAS_SINE) begin : g_sine
            lscpwm_sine #(.CNT_W(CNT_W), .PH_W(PH_W)) u_sine (
                .clk    (clk),
                .rst_n  (rst_n),
                .step_i (phase_step),
                .top_i  (carrier_top),
                .mod_o  (sine_mod)
            );
        end else begin : g_no_sine
            assign sine_mod = '0;
        end
    endgenerate

    // Pick the modulation source
    always_comb begin
        mod_sel = (HAS_SINE && use_int_sine) ? sine_mod : mod_sample;
    end

    lscpwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .mod_i  (mod_sel),
        .cnt_i  (cnt),
        .top_i  (carrier_top),
        .peak_i (peak),
        .a_o    (drive_a),
        .b_o    (drive_b),
        .err_o  (combo_err)
    );

    assign carrier_peak = peak;

endmodule

// File: tb/tb_lscpwm_top.sv
`timescale 1ns/1ps
// Bench for lscpwm_top: a vector table of duty measurements, then directed
// tests for reset, period, capture timing and the internal sine source.
module tb_lscpwm_top;

    localparam int CNT_W = 8;
    localparam int PH_W  = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic signed [CNT_W:0] mod_sample = '0;
    logic [CNT_W-1:0]      carrier_top = 8'd8;
    logic                  use_int_sine = 1'b0;
    logic [PH_W-1:0]       phase_step = '0;
    logic                  drive_a;
    logic                  drive_b;
    logic                  carrier_peak;
    logic                  combo_err;

    int n_chk = 0;
    int n_bad = 0;

    lscpwm_top #(.CNT_W(CNT_W), .PH_W(PH_W), .HAS_SINE(1'b1)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_sample   (mod_sample),
        .carrier_top  (carrier_top),
        .use_int_sine (use_int_sine),
        .phase_step   (phase_step),
        .drive_a      (drive_a),
        .drive_b      (drive_b),
        .carrier_peak (carrier_peak),
        .combo_err    (combo_err)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Vectors: top, captured value, expected A-high clocks, expected B-high clocks
    localparam int VN = 9;
    localparam int V_TOP [VN] = '{8, 8, 8, 8, 8, 8, 8, 5, 5};
    localparam int V_M   [VN] = '{3, 0, 8, -3, -8, -7, 9, 2, -1};
    localparam int V_A   [VN] = '{5, 0, 15, 0, 0, 0, 16, 3, 0};
    localparam int V_B   [VN] = '{16, 15, 16, 9, 0, 1, 16, 10, 7};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_peak();
        do @(negedge clk); while (!carrier_peak);
    endtask

    // Count A/B high and illegal pairs over one period that follows a peak.
    // If swap is set, mod_sample is changed right after the capture.
    task automatic measure(input bit swap, input int swap_val,
                           output int na, output int nb, output int nill);
        na = 0; nb = 0; nill = 0;
        wait_peak();
        @(negedge clk);
        if (swap) mod_sample = (CNT_W+1)'(swap_val);
        for (int k = 0; k < 2 * int'(carrier_top); k++) begin
            @(negedge clk);
            na   += int'(drive_a);
            nb   += int'(drive_b);
            nill += int'(drive_a && !drive_b);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int na, nb, nill, gap, seen_a, seen_nb;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(drive_a == 1'b0, "R1 reset A", drive_a, 0);
        check(drive_b == 1'b1, "R1 reset B", drive_b, 1);
        check(combo_err == 1'b0, "R1 reset err", combo_err, 0);
        check(carrier_peak == 1'b0, "R1 count zero (top=8)", carrier_peak, 0);
        rst_n = 1'b1;

        // R2: peak spacing for two tops
        for (int t = 0; t < 2; t++) begin
            carrier_top = (t == 0) ? 8'd8 : 8'd5;
            wait_peak(); wait_peak();
            gap = 0;
            do begin @(negedge clk); gap++; end while (!carrier_peak);
            check(gap == 2 * int'(carrier_top), "R2 peak spacing", gap, 2 * int'(carrier_top));
        end

        // R4/R5/R6: duty table
        for (int i = 0; i < VN; i++) begin
            @(negedge clk);
            carrier_top = CNT_W'(V_TOP[i]);
            mod_sample  = (CNT_W+1)'(V_M[i]);
            wait_peak();
            measure(1'b0, 0, na, nb, nill);
            check(na == V_A[i], $sformatf("R4 A duty vec%0d", i), na, V_A[i]);
            check(nb == V_B[i], $sformatf("R5 B duty vec%0d", i), nb, V_B[i]);
            check(nill == 0 && !combo_err, $sformatf("R6 no A1B0 vec%0d", i), nill, 0);
        end

        // R3: a change after capture does not affect the current period
        @(negedge clk);
        carrier_top = 8'd8;
        mod_sample  = 9'sd6;
        wait_peak();
        measure(1'b1, -8, na, nb, nill);
        check(na == 11, "R3 A keeps captured value", na, 11);
        check(nb == 16, "R3 B keeps captured value", nb, 16);
        // next period uses the new value
        measure(1'b0, 0, na, nb, nill);
        check(na == 0 && nb == 0, "R3 new value at next peak", na + nb, 0);

        // R7: internal sine gives both polarities, never the illegal pair
        @(negedge clk);
        mod_sample   = '0;
        use_int_sine = 1'b1;
        phase_step   = 16'd512;
        seen_a = 0; seen_nb = 0; nill = 0;
        repeat (512) begin
            @(negedge clk);
            seen_a  += int'(drive_a);
            seen_nb += int'(!drive_b);
            nill    += int'(drive_a && !drive_b);
        end
        check(seen_a > 0, "R7 sine positive pulses", seen_a, 1);
        check(seen_nb > 0, "R7 sine negative pulses", seen_nb, 1);
        check(nill == 0, "R7 sine no A1B0", nill, 0);
        check(combo_err == 1'b0, "R6 flag stays clear", combo_err, 0);

        // R1: reset in mid-run
        @(negedge clk);
        use_int_sine = 1'b0;
        mod_sample   = 9'sd8;
        rst_n = 1'b0;
        @(negedge clk);
        check(drive_a == 1'b0 && drive_b == 1'b1, "R1 mid-run reset pair",
              {drive_a, drive_b}, 1);
        check(carrier_peak == 1'b0, "R1 mid-run count zero", carrier_peak, 0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule